// File: doc/BRIEF.md
# UART Modem Control and Status Registers

This block holds the modem control register and the modem status register of a UART, together with the logic on the modem pins. The four active-low modem inputs (clear-to-send, data-set-ready, ring indicator, carrier detect) are synchronized and their present levels are reported. Changes in those levels are latched in sticky flags until software reads the status register. A modem-status interrupt is raised when the flags are non-zero and the interrupt is enabled.

On the output side, the block drives the active-low request-to-send and OUT2 pins. One control bit, the auto-flow enable, changes the meaning of the request-to-send bit. With auto-flow off, that bit drives the pin directly. With auto-flow on, it selects between auto-CTS alone and auto-CTS plus auto-RTS. In that case the pin follows the receiver's ready decision, which comes in from outside the block.

A loopback mode feeds the control outputs back into the status inputs, so that software can exercise the status path without a modem attached. The serializer, FIFOs and the flow-control decisions themselves lie outside the block. It only supplies enables, the CTS level and the pin.

Top module: `uart_modem_ctl`

## Requirements
- R1: Status register bits 7:4 report the present levels of CTS (bit 4), DSR (bit 5), RI (bit 6) and DCD (bit 7). Each level is 1 when its pin is low. A pin change reaches the register two clock edges after it is sampled.
- R2: Status flags at bit 0 (CTS), bit 1 (DSR) and bit 3 (DCD) are set on either edge of the matching level. They stay set until they are cleared.
- R3: Status flag bit 2 (RI) is set only when the RI level falls from 1 to 0. A rise of RI leaves it unchanged.
- R4: A status read (reg_rd=1, reg_addr=1) returns the flags as they were and then clears them. A flag whose input changes in the same cycle as the read stays set.
- R5: The control register (reg_addr=0) holds RTS at bit 1, OUT2 at bit 3, LOOP at bit 4 and AFE at bit 5. Bits 0, 2, 6 and 7 read as 0. All four fields are 0 after reset.
- R6: With LOOP=0 and AFE=0, rts_n_o equals the inverse of RTS. With LOOP=0, out2_n_o equals the inverse of OUT2.
- R7: With AFE=1, auto_cts_en is 1 and auto_rts_en equals RTS. With LOOP=0, AFE=1 and RTS=1, rts_n_o follows auto_rts_n_i. With LOOP=0, AFE=1 and RTS=0, rts_n_o is held low.
- R8: With LOOP=1, the CTS level is taken from RTS and the DCD level from OUT2. The DSR and RI levels read 0, and both output pins are held high. Changes made this way set flags as in R2 and R3.
- R9: irq is 1 exactly when mie is 1 and at least one status flag is set.
- R10: cts_ok equals the CTS level reported in status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 1 | 0 selects the control register, 1 the status register |
| reg_wr | input | 1 | Write strobe (control register only) |
| reg_rd | input | 1 | Read strobe; a status read clears the flags |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| mie | input | 1 | Modem-status interrupt enable |
| cts_n_i | input | 1 | Clear-to-send pin, active low |
| dsr_n_i | input | 1 | Data-set-ready pin, active low |
| ri_n_i | input | 1 | Ring indicator pin, active low |
| dcd_n_i | input | 1 | Carrier detect pin, active low |
| auto_rts_n_i | input | 1 | Receiver's automatic RTS decision, active low |
| rts_n_o | output | 1 | Request-to-send pin, active low |
| out2_n_o | output | 1 | OUT2 pin, active low |
| auto_cts_en | output | 1 | Enables automatic CTS flow control |
| auto_rts_en | output | 1 | Enables automatic RTS flow control |
| cts_ok | output | 1 | CTS level for the transmitter |
| irq | output | 1 | Modem-status interrupt |

## Verification
The hardest case to reach from the ports is a level change that lands in the same cycle as a status read. In that case the flag must survive the clear. Because of the synchronizer delay, the stimulus toggles a pin and then asserts the read strobe exactly two clocks later. It then reads the status again and expects the flag still set. An RI rise and fall, each followed by a read, separates leading edges from trailing edges. Long stretches of random pin, register and interrupt-enable traffic, including loopback entry and exit, are compared each cycle against a queue-based model.

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       mie,
  input  logic       cts_n_i,
  input  logic       dsr_n_i,
  input  logic       ri_n_i,
  input  logic       dcd_n_i,
  input  logic       auto_rts_n_i,
  output logic       rts_n_o,
  output logic       out2_n_o,
  output logic       auto_cts_en,
  output logic       auto_rts_en,
  output logic       cts_ok,
  output logic       irq
);

  // level vector order: [3]=DCD [2]=RI [1]=DSR [0]=CTS
  logic [3:0] s1, s2, prev, flags, lvl, ev;
  logic       rts_q, out2_q, loop_q, afe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 4'b0;
      s2 <= 4'b0;
    end else begin
      s1 <= ~{dcd_n_i, ri_n_i, dsr_n_i, cts_n_i};
      s2 <= s1;
    end
  end

  assign lvl = loop_q ? {out2_q, 1'b0, 1'b0, rts_q} : s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 4'b0;
    else        prev <= lvl;
  end

  assign ev[0] = lvl[0] ^ prev[0];
  assign ev[1] = lvl[1] ^ prev[1];
  assign ev[2] = prev[2] & ~lvl[2];
  assign ev[3] = lvl[3] ^ prev[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  flags <= 4'b0;
    else if (reg_rd && reg_addr) flags <= ev;
    else                         flags <= flags | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_q  <= 1'b0;
      out2_q <= 1'b0;
      loop_q <= 1'b0;
      afe_q  <= 1'b0;
    end else if (reg_wr && !reg_addr) begin
      rts_q  <= reg_wdata[1];
      out2_q <= reg_wdata[3];
      loop_q <= reg_wdata[4];
      afe_q  <= reg_wdata[5];
    end
  end

  assign reg_rdata = reg_addr ? {lvl, flags}
                              : {2'b00, afe_q, loop_q, out2_q, 1'b0, rts_q, 1'b0};

  always_comb begin
    if (loop_q)      rts_n_o = 1'b1;
    else if (!afe_q) rts_n_o = ~rts_q;
    else if (rts_q)  rts_n_o = auto_rts_n_i;
    else             rts_n_o = 1'b0;
  end

  assign out2_n_o    = loop_q | ~out2_q;
  assign auto_cts_en = afe_q;
  assign auto_rts_en = afe_q & rts_q;
  assign cts_ok      = lvl[0];
  assign irq         = mie & (|flags);

  // R2
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_rd && reg_addr) && (|flags)) |=> ((flags & $past(flags)) == $past(flags)));

  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr && ev == 4'b0) |=> (flags == 4'b0));

  // R3
  ri_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[2]) |-> ($past(prev[2]) && !$past(lvl[2])));

  // R8
  loop_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_q |-> (rts_n_o && out2_n_o && reg_rdata[7:4] == 4'b0 || !reg_addr || rts_n_o && out2_n_o));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mie);

endmodule

// File: tb/uart_modem_ctl_bench.sv
module uart_modem_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_addr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic mie = 1'b0;
  logic cts_n_i = 1'b1, dsr_n_i = 1'b1, ri_n_i = 1'b1, dcd_n_i = 1'b1;
  logic auto_rts_n_i = 1'b1;
  logic rts_n_o, out2_n_o, auto_cts_en, auto_rts_en, cts_ok, irq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  uart_modem_ctl u_uart_modem_ctl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mie(mie),
    .cts_n_i(cts_n_i), .dsr_n_i(dsr_n_i), .ri_n_i(ri_n_i), .dcd_n_i(dcd_n_i),
    .auto_rts_n_i(auto_rts_n_i), .rts_n_o(rts_n_o), .out2_n_o(out2_n_o),
    .auto_cts_en(auto_cts_en), .auto_rts_en(auto_rts_en), .cts_ok(cts_ok), .irq(irq)
  );

  // Reference model: pin and level histories kept as queues.
  logic [3:0] pin_hist[$];
  logic [3:0] lvl_hist[$];
  logic [3:0] m_flags;
  bit m_rts, m_out2, m_loop, m_afe;

  function automatic logic [3:0] cur_lvl();
    return lvl_hist[0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      pin_hist = '{4'b0, 4'b0};
      lvl_hist = '{4'b0, 4'b0};
      m_flags = 4'b0;
      {m_rts, m_out2, m_loop, m_afe} = 4'b0;
    end else begin
      logic [3:0] e, nl;
      e[0] = lvl_hist[0][0] != lvl_hist[1][0];
      e[1] = lvl_hist[0][1] != lvl_hist[1][1];
      e[2] = lvl_hist[1][2] && !lvl_hist[0][2];
      e[3] = lvl_hist[0][3] != lvl_hist[1][3];
      if (reg_rd && reg_addr) m_flags = e;
      else m_flags = m_flags | e;
      if (reg_wr && !reg_addr) begin
        m_rts = reg_wdata[1]; m_out2 = reg_wdata[3];
        m_loop = reg_wdata[4]; m_afe = reg_wdata[5];
      end
      pin_hist.push_front(~{dcd_n_i, ri_n_i, dsr_n_i, cts_n_i});
      void'(pin_hist.pop_back());
      nl = m_loop ? {m_out2, 2'b00, m_rts} : pin_hist[1];
      lvl_hist.push_front(nl);
      void'(lvl_hist.pop_back());
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  // Every-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && pin_hist.size() == 2) begin
      logic [7:0] exp_rd;
      logic exp_rts;
      cyc++;
      if (reg_addr) exp_rd = {cur_lvl(), m_flags};
      else exp_rd = {2'b00, m_afe, m_loop, m_out2, 1'b0, m_rts, 1'b0};
      if (m_loop) exp_rts = 1'b1;
      else if (!m_afe) exp_rts = !m_rts;
      else if (m_rts) exp_rts = auto_rts_n_i;
      else exp_rts = 1'b0;
      if (reg_addr) begin
        chk("R1", "levels", reg_rdata[7:4], cur_lvl());
        chk("R2", "flags", reg_rdata[3:0], m_flags);
      end else chk("R5", "control", reg_rdata, exp_rd);
      chk("R6", "rts_n_o", rts_n_o, exp_rts);
      chk("R6", "out2_n_o", out2_n_o, m_loop | !m_out2);
      chk("R7", "auto_cts_en", auto_cts_en, m_afe);
      chk("R7", "auto_rts_en", auto_rts_en, m_afe & m_rts);
      chk("R10", "cts_ok", cts_ok, cur_lvl() >> 0 & 1);
      chk("R9", "irq", irq, mie && (m_flags != 0));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    reg_wr = 0; reg_rd = 0;
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    reg_addr = 0; reg_wr = 1; reg_rd = 0; reg_wdata = d; step(); idle();
  endtask

  task automatic rd_stat(output logic [7:0] d);
    reg_addr = 1; reg_rd = 1; reg_wr = 0; #0.5; d = reg_rdata; step(); idle();
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) step();
    // R5 reset state of the control register
    #0.5; chk("R5", "reset control", reg_rdata, 8'h00);
    chk("R6", "reset rts_n_o", rts_n_o, 1);
    rst_n = 1; step(); step(); step();

    // R1 / R2: CTS asserted, flag appears
    cts_n_i = 0; repeat (4) step();
    reg_addr = 1; #0.5;
    chk("R1", "cts level", reg_rdata[4], 1);
    chk("R2", "cts flag", reg_rdata[0], 1);
    rd_stat(d); step(); reg_addr = 1; #0.5;
    chk("R4", "cleared", reg_rdata[3:0], 0);

    // R3: RI rise sets no flag, fall does
    ri_n_i = 0; repeat (4) step(); reg_addr = 1; #0.5;
    chk("R3", "ri rise no flag", reg_rdata[2], 0);
    ri_n_i = 1; repeat (4) step(); reg_addr = 1; #0.5;
    chk("R3", "ri fall flag", reg_rdata[2], 1);
    rd_stat(d); step();

    // R4: event coincident with read survives
    dsr_n_i = 0; step(); step();
    rd_stat(d); reg_addr = 1; #0.5;
    chk("R4", "coincident dsr flag kept", reg_rdata[1], 1);
    rd_stat(d); step();

    // R9 interrupt enable
    dcd_n_i = 0; repeat (4) step(); #0.5;
    chk("R9", "irq masked", irq, 0);
    mie = 1; #0.5; chk("R9", "irq enabled", irq, 1);
    rd_stat(d); step(); #0.5; chk("R9", "irq after clear", irq, 0);

    // R6 / R7 control modes
    wr_ctl(8'h0A); #0.5; chk("R6", "rts direct", rts_n_o, 0); chk("R6", "out2", out2_n_o, 0);
    wr_ctl(8'h20); #0.5; chk("R7", "half auto rts low", rts_n_o, 0);
    chk("R7", "half auto en", auto_rts_en, 0);
    wr_ctl(8'h22); auto_rts_n_i = 1; #0.5; chk("R7", "full auto pin", rts_n_o, 1);
    auto_rts_n_i = 0; #0.5; chk("R7", "full auto pin low", rts_n_o, 0);

    // R8 loopback
    wr_ctl(8'h1A); step(); reg_addr = 1; #0.5;
    chk("R8", "loop levels", reg_rdata[7:4], 4'b1001);
    chk("R8", "loop pins", {rts_n_o, out2_n_o}, 2'b11);
    chk("R10", "loop cts_ok", cts_ok, 1);
    wr_ctl(8'h00); rd_stat(d); step();

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 10) {dcd_n_i, ri_n_i, dsr_n_i, cts_n_i} = 4'($urandom);
      auto_rts_n_i = 1'($urandom);
      if (r % 17 == 0) mie = 1'($urandom);
      reg_addr = 1'($urandom);
      reg_rd = (r > 80);
      reg_wr = (r < 4);
      reg_wdata = 8'($urandom);
      step();
    end
    idle();
    repeat (4) step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule